// File: doc/BRIEF.md
# Biphase Mark Packet Transmitter

This block sends one power-negotiation message over a single shared, half-duplex configuration wire. Before a send, the message content is staged. The 16-bit header comes in on a parallel input, and up to seven 32-bit data objects are written one at a time into an internal object store. A one-cycle start pulse then launches the packet.

The block frames the message and serialises it with biphase mark coding. The frame is:

1. A 64-bit alternating training run.
2. A start delimiter made of reserved 5-bit codes.
3. The header and the data objects, each nibble expanded to a 5-bit code.
4. A 32-bit checksum.
5. An end delimiter.

The bit rate comes from a half-cell divider given in system clocks. For example, a divider near 167 at a 100 MHz clock gives a signalling rate of about 300 kbit/s.

The block drives the wire only while a packet is in flight. After the last symbol it holds the line low for one bit cell and then releases the output enable. A busy flag covers the whole send, and a one-cycle done pulse marks the release.

Top module: `biphase_pkt_tx`

## Requirements
- R1: After reset, and whenever no packet is in progress, line_oe_o, line_o, busy_o and done_o are all 0.
- R2: Every bit cell begins with a level change on line_o. A bit of value 1 adds a second change at the middle of the cell; a 0 has none.
- R3: Each half cell lasts half_div_i clocks, latched at start, with 0 treated as 1. line_o is constant within each half cell. line_oe_o stays high for exactly (2N+2) half-cells times that length, where N is the number of bits sent. Cell 0 begins in the first cycle that line_oe_o is high.
- R4: The bit stream starts with 64 training bits 0,1,0,1,..., beginning with 0. Then follow three codes 11000 and one code 10001. Every 5-bit code is written here msb-left and sent bit 0 first.
- R5: Next come the header nibbles and then the data objects, nibble 0 of each word first. The number of objects is header bits 14:12. Each nibble is sent as a 5-bit code from this table: 0 11110, 1 01001, 2 10100, 3 10101, 4 01010, 5 01011, 6 01110, 7 01111, 8 10010, 9 10011, A 10110, B 10111, C 11010, D 11011, E 11100, F 11101.
- R6: Next come 8 nibbles of checksum, low nibble first, coded through the same table, followed by the end code 01101. The checksum is CRC-32 with polynomial 0x04C11DB7 in bit-reflected form, seeded with all ones and inverted at the end. It covers the header and then the objects, each taken bit 0 first.
- R7: After the last cell, line_o is 0 for one full bit cell, after which line_oe_o falls.
- R8: busy_o rises in the cycle after an accepted start and stays high until the cycle in which line_oe_o falls. done_o is high for exactly that one cycle.
- R9: A start pulse while busy_o is high is ignored. The packet in flight keeps its header, rate and length.
- R10: Object writes while busy_o is high are ignored. Both the packet in flight and later packets use the earlier contents.
- R11: Packets with zero objects and with seven objects are framed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div_i | input | 16 | Half bit-cell length in clocks, latched at start |
| hdr_i | input | 16 | Message header, latched at start; bits 14:12 give the object count |
| obj_we_i | input | 1 | Object store write strobe |
| obj_sel_i | input | 3 | Object slot to write |
| obj_data_i | input | 32 | Object word to write |
| start_i | input | 1 | Start pulse, accepted only while idle |
| line_o | output | 1 | Coded line level |
| line_oe_o | output | 1 | Line drive enable |
| busy_o | output | 1 | Send in progress |
| done_o | output | 1 | One-cycle pulse at line release |

## Verification
The assertions take for granted that a reset opens the run, and that the object store and header are written only through the ports. They also assume line_o is judged only against line_oe_o and the busy flag, never against the timing of the far end. The stimulus changes inputs only at falling clock edges, so each start pulse and each write lands cleanly on one rising edge. Every header's count field stays within the seven slots. The only inputs applied mid-packet are the extra start pulse and the object write, and the bench checks that both leave the packet unchanged.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

    localparam int HDR_W   = 16;
    localparam int OBJ_W   = 32;
    localparam int SYM_W   = 5;
    localparam int CNT_LSB = 12;

    // 5-bit reserved codes, bit 0 leaves first
    localparam logic [SYM_W-1:0] K_SYNC_A = 5'b11000;
    localparam logic [SYM_W-1:0] K_SYNC_B = 5'b10001;
    localparam logic [SYM_W-1:0] K_END    = 5'b01101;
    localparam logic [SYM_W-1:0] TRAIN_PAIR = 5'b00010;

    typedef enum logic [2:0] {
        FR_IDLE, FR_PRE, FR_SOP, FR_PAY, FR_CRC, FR_EOP
    } fr_state_e;

    typedef enum logic [1:0] {
        EN_IDLE, EN_RUN, EN_HOLD
    } en_state_e;

    typedef struct packed {
        logic [SYM_W-1:0] code;
        logic [2:0]       len;
    } unit_t;

    function automatic logic [SYM_W-1:0] nib_to_sym(input logic [3:0] n);
        logic [SYM_W-1:0] s;
        case (n)
            4'h0: s = 5'b11110;
            4'h1: s = 5'b01001;
            4'h2: s = 5'b10100;
            4'h3: s = 5'b10101;
            4'h4: s = 5'b01010;
            4'h5: s = 5'b01011;
            4'h6: s = 5'b01110;
            4'h7: s = 5'b01111;
            4'h8: s = 5'b10010;
            4'h9: s = 5'b10011;
            4'hA: s = 5'b10110;
            4'hB: s = 5'b10111;
            4'hC: s = 5'b11010;
            4'hD: s = 5'b11011;
            4'hE: s = 5'b11100;
            default: s = 5'b11101;
        endcase
        return s;
    endfunction

    // Reflected CRC-32 advanced over one nibble, bit 0 first
    function automatic logic [31:0] crc_step4(input logic [31:0] c, input logic [3:0] n);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 4; i++) begin
            fb = r[0] ^ n[i];
            r  = r >> 1;
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

endpackage

// File: rtl/bpt_obj_store.sv
module bpt_obj_store #(
    parameter int DEPTH = 7,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic          lock_i,
    input  logic [AW-1:0] wsel_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] rsel_i,
    output logic [W-1:0]  rdata_o
);

    localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

    logic [W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (we_i && !lock_i && ({1'b0, wsel_i} == (AW+1)'(g))) begin
                slot_q[g] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if ({1'b0, rsel_i} < DEPTH_L) rdata_o = slot_q[rsel_i];
    end

endmodule

// File: rtl/bpt_framer.sv
module bpt_framer
    import bpt_pkg::*;
#(
    parameter int MAX_OBJ  = 7,
    parameter int PRE_BITS = 64,
    localparam int AW      = $clog2(MAX_OBJ + 1),
    localparam int PRE_UNITS = PRE_BITS / 2,
    localparam int UW      = $clog2(PRE_UNITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic [HDR_W-1:0] hdr_i,
    input  logic [AW-1:0]    obj_cnt_i,
    input  logic [OBJ_W-1:0] obj_data_i,
    output logic [AW-1:0]    obj_sel_o,
    input  logic             adv_i,
    output logic             bit_o,
    output logic             last_o
);

    localparam int SOP_UNITS = 4;

    fr_state_e   st_q;
    logic [UW-1:0] ucnt_q;
    logic [2:0]  bcnt_q;
    logic [AW-1:0] word_q;
    logic [2:0]  nib_q;
    logic [31:0] crc_q;
    logic [3:0]  pay_nib;
    logic [3:0]  crc_nib;
    unit_t       cur;
    logic        unit_end;

    always_comb begin
        obj_sel_o = (word_q == '0) ? '0 : word_q - 1'b1;
        pay_nib   = (word_q == '0) ? hdr_i[{nib_q[1:0], 2'b00} +: 4]
                                   : obj_data_i[{nib_q, 2'b00} +: 4];
        crc_nib   = ~crc_q[{nib_q, 2'b00} +: 4];
        cur.len   = 3'd5;
        cur.code  = '0;
        case (st_q)
            FR_PRE: begin
                cur.code = TRAIN_PAIR;
                cur.len  = 3'd2;
            end
            FR_SOP: cur.code = (ucnt_q == UW'(SOP_UNITS - 1)) ? K_SYNC_B : K_SYNC_A;
            FR_PAY: cur.code = nib_to_sym(pay_nib);
            FR_CRC: cur.code = nib_to_sym(crc_nib);
            FR_EOP: cur.code = K_END;
            default: cur.code = '0;
        endcase
        bit_o    = cur.code[bcnt_q];
        last_o   = (st_q == FR_EOP) && (bcnt_q == 3'd4);
        unit_end = adv_i && (bcnt_q == cur.len - 3'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= FR_IDLE;
            ucnt_q <= '0;
            bcnt_q <= '0;
            word_q <= '0;
            nib_q  <= '0;
            crc_q  <= '1;
        end else if (go_i) begin
            st_q   <= FR_PRE;
            ucnt_q <= '0;
            bcnt_q <= '0;
            word_q <= '0;
            nib_q  <= '0;
            crc_q  <= '1;
        end else if (adv_i && st_q != FR_IDLE) begin
            if (!unit_end) begin
                bcnt_q <= bcnt_q + 3'd1;
            end else begin
                bcnt_q <= '0;
                case (st_q)
                    FR_PRE: begin
                        if (ucnt_q == UW'(PRE_UNITS - 1)) begin
                            st_q   <= FR_SOP;
                            ucnt_q <= '0;
                        end else begin
                            ucnt_q <= ucnt_q + 1'b1;
                        end
                    end
                    FR_SOP: begin
                        if (ucnt_q == UW'(SOP_UNITS - 1)) begin
                            st_q   <= FR_PAY;
                            word_q <= '0;
                            nib_q  <= '0;
                        end else begin
                            ucnt_q <= ucnt_q + 1'b1;
                        end
                    end
                    FR_PAY: begin
                        crc_q <= crc_step4(crc_q, pay_nib);
                        if (word_q == '0) begin
                            if (nib_q == 3'd3) begin
                                nib_q <= '0;
                                if (obj_cnt_i == '0) st_q <= FR_CRC;
                                else word_q <= AW'(1);
                            end else begin
                                nib_q <= nib_q + 3'd1;
                            end
                        end else begin
                            if (nib_q == 3'd7) begin
                                nib_q <= '0;
                                if (word_q == obj_cnt_i) st_q <= FR_CRC;
                                else word_q <= word_q + 1'b1;
                            end else begin
                                nib_q <= nib_q + 3'd1;
                            end
                        end
                    end
                    FR_CRC: begin
                        if (nib_q == 3'd7) st_q <= FR_EOP;
                        else nib_q <= nib_q + 3'd1;
                    end
                    default: st_q <= FR_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/bpt_line_enc.sv
module bpt_line_enc
    import bpt_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             bit_i,
    input  logic             last_i,
    output logic             adv_o,
    output logic             rel_o,
    output logic             line_o,
    output logic             oe_o,
    output logic             done_o
);

    en_state_e        st_q;
    logic [DIV_W-1:0] hlen_q;
    logic [DIV_W-1:0] hcnt_q;
    logic             half_q;
    logic             line_q;
    logic             done_q;
    logic             half_end;

    always_comb begin
        half_end = (st_q != EN_IDLE) && (hcnt_q == hlen_q - 1'b1);
        adv_o    = (st_q == EN_RUN)  && half_end && half_q;
        rel_o    = (st_q == EN_HOLD) && half_end && half_q;
        oe_o     = (st_q != EN_IDLE);
        line_o   = line_q;
        done_o   = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= EN_IDLE;
            hlen_q <= DIV_W'(1);
            hcnt_q <= '0;
            half_q <= 1'b0;
            line_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go_i && st_q == EN_IDLE) begin
                st_q   <= EN_RUN;
                hlen_q <= (div_i == '0) ? DIV_W'(1) : div_i;
                hcnt_q <= '0;
                half_q <= 1'b0;
                line_q <= ~line_q;
            end else if (st_q != EN_IDLE) begin
                if (!half_end) begin
                    hcnt_q <= hcnt_q + 1'b1;
                end else begin
                    hcnt_q <= '0;
                    half_q <= ~half_q;
                    if (!half_q) begin
                        if (st_q == EN_RUN && bit_i) line_q <= ~line_q;
                    end else if (st_q == EN_RUN) begin
                        if (last_i) begin
                            st_q   <= EN_HOLD;
                            line_q <= 1'b0;
                        end else begin
                            line_q <= ~line_q;
                        end
                    end else begin
                        st_q   <= EN_IDLE;
                        done_q <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/biphase_pkt_tx.sv
module biphase_pkt_tx
    import bpt_pkg::*;
#(
    parameter int MAX_OBJ  = 7,
    parameter int PRE_BITS = 64,
    parameter int DIV_W    = 16,
    localparam int AW      = $clog2(MAX_OBJ + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] half_div_i,
    input  logic [HDR_W-1:0] hdr_i,
    input  logic             obj_we_i,
    input  logic [AW-1:0]    obj_sel_i,
    input  logic [OBJ_W-1:0] obj_data_i,
    input  logic             start_i,
    output logic             line_o,
    output logic             line_oe_o,
    output logic             busy_o,
    output logic             done_o
);

    logic             busy_q;
    logic [HDR_W-1:0] hdr_q;
    logic             go;
    logic             adv;
    logic             rel;
    logic             tx_bit;
    logic             tx_last;
    logic [AW-1:0]    rd_sel;
    logic [OBJ_W-1:0] rd_data;

    assign go     = start_i && !busy_q;
    assign busy_o = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            hdr_q  <= '0;
        end else if (go) begin
            busy_q <= 1'b1;
            hdr_q  <= hdr_i;
        end else if (rel) begin
            busy_q <= 1'b0;
        end
    end

    bpt_obj_store #(.DEPTH(MAX_OBJ), .W(OBJ_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we_i    (obj_we_i),
        .lock_i  (busy_q),
        .wsel_i  (obj_sel_i),
        .wdata_i (obj_data_i),
        .rsel_i  (rd_sel),
        .rdata_o (rd_data)
    );

    bpt_framer #(.MAX_OBJ(MAX_OBJ), .PRE_BITS(PRE_BITS)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .go_i       (go),
        .hdr_i      (hdr_q),
        .obj_cnt_i  (hdr_q[CNT_LSB +: AW]),
        .obj_data_i (rd_data),
        .obj_sel_o  (rd_sel),
        .adv_i      (adv),
        .bit_o      (tx_bit),
        .last_o     (tx_last)
    );

    bpt_line_enc #(.DIV_W(DIV_W)) u_enc (
        .clk    (clk),
        .rst    (rst),
        .go_i   (go),
        .div_i  (half_div_i),
        .bit_i  (tx_bit),
        .last_i (tx_last),
        .adv_o  (adv),
        .rel_o  (rel),
        .line_o (line_o),
        .oe_o   (line_oe_o),
        .done_o (done_o)
    );

endmodule

// File: rtl/biphase_pkt_tx_chk.sv
module biphase_pkt_tx_chk (
    input logic clk,
    input logic rst,
    input logic line_o,
    input logic line_oe_o,
    input logic busy_o,
    input logic done_o
);

    // R8
    busy_tracks_oe_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o == line_oe_o);

    // R1
    released_low_chk: assert property (@(posedge clk) disable iff (rst)
        !line_oe_o |-> !line_o);

    // R7
    hold_before_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(line_oe_o) |-> !$past(line_o));

    // R8
    done_at_release_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

bind biphase_pkt_tx biphase_pkt_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_o    (line_o),
    .line_oe_o (line_oe_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/sim_biphase_pkt_tx.sv
`timescale 1ns/1ps
module sim_biphase_pkt_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] half_div_i = 16'd2;
    logic [15:0] hdr_i = '0;
    logic        obj_we_i = 1'b0;
    logic [2:0]  obj_sel_i = '0;
    logic [31:0] obj_data_i = '0;
    logic        start_i = 1'b0;
    logic        line_o, line_oe_o, busy_o, done_o;

    biphase_pkt_tx u0 (
        .clk(clk), .rst(rst), .half_div_i(half_div_i), .hdr_i(hdr_i),
        .obj_we_i(obj_we_i), .obj_sel_i(obj_sel_i), .obj_data_i(obj_data_i),
        .start_i(start_i), .line_o(line_o), .line_oe_o(line_oe_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] objs [7];
    logic xb [1024];
    int   xn;
    int   pay_at, crc_at;
    logic lv [4096];
    int   lt;

    function automatic logic [4:0] t45(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110; 4'h1: return 5'b01001;
            4'h2: return 5'b10100; 4'h3: return 5'b10101;
            4'h4: return 5'b01010; 4'h5: return 5'b01011;
            4'h6: return 5'b01110; 4'h7: return 5'b01111;
            4'h8: return 5'b10010; 4'h9: return 5'b10011;
            4'hA: return 5'b10110; 4'hB: return 5'b10111;
            4'hC: return 5'b11010; 4'hD: return 5'b11011;
            4'hE: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    function automatic logic [31:0] cbit(input logic [31:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_sym(input logic [4:0] s);
        for (int i = 0; i < 5; i++) begin
            xb[xn] = s[i];
            xn++;
        end
    endtask

    task automatic build(input logic [15:0] hdr);
        int nobj;
        logic [31:0] crc;
        nobj = int'(hdr[14:12]);
        crc  = '1;
        xn   = 0;
        for (int i = 0; i < 64; i++) begin
            xb[xn] = logic'(i % 2);
            xn++;
        end
        push_sym(5'b11000); push_sym(5'b11000); push_sym(5'b11000);
        push_sym(5'b10001);
        pay_at = xn;
        for (int k = 0; k < 4; k++) push_sym(t45(hdr[4*k +: 4]));
        for (int b = 0; b < 16; b++) crc = cbit(crc, hdr[b]);
        for (int w = 0; w < nobj; w++) begin
            for (int k = 0; k < 8; k++) push_sym(t45(objs[w][4*k +: 4]));
            for (int b = 0; b < 32; b++) crc = cbit(crc, objs[w][b]);
        end
        crc_at = xn;
        crc = ~crc;
        for (int k = 0; k < 8; k++) push_sym(t45(crc[4*k +: 4]));
        push_sym(5'b01101);
    endtask

    task automatic load_obj(input int i, input logic [31:0] v);
        @(negedge clk);
        obj_we_i = 1'b1; obj_sel_i = 3'(i); obj_data_i = v;
        @(negedge clk);
        obj_we_i = 1'b0;
        objs[i] = v;
    endtask

    task automatic send(input logic [15:0] hdr, input logic [15:0] div,
                        input bit inject, input string tag);
        int h, e_pre, e_sop, e_pay, e_crc, e_tog, e_flat, e_hold, base, want;
        logic a, b, prev;
        h = (div == 0) ? 1 : int'(div);
        build(hdr);
        e_pre = 0; e_sop = 0; e_pay = 0; e_crc = 0;
        e_tog = 0; e_flat = 0; e_hold = 0; prev = 1'b0;
        @(negedge clk);
        hdr_i = hdr; half_div_i = div; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b1 && line_oe_o === 1'b1, "R8", {tag, " busy after start"},
            int'(busy_o), 1);
        lt = 0;
        while (line_oe_o === 1'b1 && lt < 4096) begin
            lv[lt] = line_o;
            if (inject && lt == 10) begin hdr_i = 16'hFFFF; half_div_i = 16'd7; start_i = 1'b1; end
            if (inject && lt == 11) start_i = 1'b0;
            if (inject && lt == 20) begin obj_we_i = 1'b1; obj_sel_i = 3'd0; obj_data_i = 32'hDEAD0000; end
            if (inject && lt == 21) obj_we_i = 1'b0;
            @(negedge clk);
            lt++;
        end
        want = (2 * xn + 2) * h;
        chk(lt == want, "R3", {tag, " enable duration"}, lt, want);
        chk(done_o === 1'b1 && busy_o === 1'b0, "R8", {tag, " done at release"},
            int'(done_o), 1);
        if (lt == want) begin
            for (int k = 0; k < xn; k++) begin
                base = 2 * k * h;
                a = lv[base];
                b = lv[base + h];
                for (int j = 0; j < h; j++)
                    if (lv[base + j] !== a || lv[base + h + j] !== b) e_flat++;
                if (a === prev) e_tog++;
                if ((a ^ b) !== xb[k]) begin
                    if (k < 64) e_pre++;
                    else if (k < pay_at) e_sop++;
                    else if (k < crc_at) e_pay++;
                    else e_crc++;
                end
                prev = b;
            end
            for (int j = 0; j < 2 * h; j++)
                if (lv[2 * xn * h + j] !== 1'b0) e_hold++;
        end
        chk(e_tog == 0, "R2", {tag, " cell boundary changes missing"}, e_tog, 0);
        chk(e_flat == 0, "R3", {tag, " half-cell level unstable"}, e_flat, 0);
        chk(e_pre == 0, "R4", {tag, " training bits wrong"}, e_pre, 0);
        chk(e_sop == 0, "R4", {tag, " start delimiter wrong"}, e_sop, 0);
        chk(e_pay == 0, "R5", {tag, " payload bits wrong"}, e_pay, 0);
        chk(e_crc == 0, "R6", {tag, " checksum or end code wrong"}, e_crc, 0);
        chk(e_hold == 0, "R7", {tag, " final hold not low"}, e_hold, 0);
        if (inject) begin
            chk(lt == want && e_pay == 0 && e_sop == 0, "R9",
                {tag, " start while busy altered packet"}, lt, want);
            chk(e_pay == 0 && e_crc == 0, "R10",
                {tag, " write while busy altered objects"}, e_pay + e_crc, 0);
        end
        @(negedge clk);
        chk(done_o === 1'b0 && line_o === 1'b0 && busy_o === 1'b0, "R1",
            {tag, " idle after release"}, int'(done_o), 0);
    endtask

    task automatic t_reset;
        chk(line_o === 1'b0 && line_oe_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
            "R1", "reset state", int'({line_o, line_oe_o, busy_o, done_o}), 0);
    endtask

    task automatic t_zero;
        send(16'h0A5C, 16'd2, 1'b0, "R11 zero objects");
    endtask

    task automatic t_two;
        load_obj(0, 32'h12345678);
        load_obj(1, 32'hCAFEF00D);
        send(16'h2B3D, 16'd3, 1'b0, "two objects");
    endtask

    task automatic t_seven;
        for (int i = 0; i < 7; i++) load_obj(i, 32'h9E3779B9 * (i + 1));
        send(16'h7F01, 16'd1, 1'b0, "R11 seven objects");
    endtask

    task automatic t_div0;
        load_obj(0, 32'h0000FFFF);
        send(16'h1234, 16'd0, 1'b0, "R3 divider zero");
    endtask

    task automatic t_busy;
        load_obj(0, 32'hA5A5C3C3);
        load_obj(1, 32'h00000001);
        load_obj(2, 32'h80000000);
        send(16'h3C00, 16'd2, 1'b1, "R9 R10 mid-packet inputs");
        send(16'h3C00, 16'd2, 1'b0, "R10 later packet");
    endtask

    initial begin
        for (int i = 0; i < 7; i++) objs[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_zero();
        t_two();
        t_seven();
        t_div0();
        t_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule